// File: doc/BRIEF.md
# Pipelined Burst SRAM Read Model

A cycle-accurate behavioural model of the read side of a synchronous pipelined burst SRAM. Either of two active-low address strobes, one meant for a processor and one for a cache controller, can start a read burst. When the device is selected in that cycle, the strobe captures the address bus as the base of a four-beat burst. In later cycles without a strobe, an active-low advance input moves the burst to the next location. The low two address bits count up modulo four and the upper bits stay fixed, so the fifth beat lands on the base again. With advance released, the burst is suspended and the same word is returned again.

The array read is registered. An address taken at clock edge n produces its data word on the data bus after edge n+1. A strobe issued while any chip enable is inactive deselects the device, and the data bus then floats within two clock edges. The data bus is driven only when the pipelined valid flag is set and output enable is low. For this reason, asserting output enable early cannot drive the bus before the first word has been clocked out. The array contents come from a backdoor task, `load_word`, in the array submodule.

The data bus is a plain tri-state output, as a memory pin is, and has no valid/ready handshake. The device cannot apply back-pressure. The consumer paces the burst by holding advance high, which repeats the current word.

Top module: `burst_sram_rd`

## Requirements
- R1: After reset the device is deselected, the burst offset is zero and `dq_o` is high impedance (all bits `z`).
- R2: A low level on either `strobe_cpu_n` or `strobe_ctl_n` while the device is selected loads `addr_i` as the burst base at that edge. The word at the base appears on `dq_o` after the following edge when `oe_n` is low.
- R3: In each cycle with no strobe and `adv_n` low during an active burst, the burst moves to the next address. The low 2 bits increase by one modulo 4 and the upper bits keep the base value.
- R4: After four beats the burst wraps back to the base address, so beat five returns the base word.
- R5: With no strobe and `adv_n` high, the burst address is unchanged and the output repeats the previous word.
- R6: A strobe in the middle of a burst abandons it, and the following beats come from the newly loaded base.
- R7: A strobe while the device is not selected ends the burst. `dq_o` is high impedance after the second rising edge following that cycle.
- R8: The device is selected only when `en_a_n` is low, `en_b_n` is low and `en_c` is high. Any one of them inactive makes a strobe cycle a deselect.
- R9: `dq_o` is driven only while the pipelined valid flag is set and `oe_n` is low. Raising `oe_n` floats the bus in the same cycle. A low `oe_n` before the first registered word leaves the bus floating.
- R10: The chip enables are sampled only in strobe cycles. Changing them in a cycle without a strobe has no effect on a running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Address bus, sampled on a strobe |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en_a_n | input | 1 | Primary chip enable, active low |
| en_b_n | input | 1 | Second chip enable, active low |
| en_c | input | 1 | Third chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| dq_o | output | DATA_W | Read data, high impedance when not driven |

## Verification
The bench builds the block with DATA_W=18, ADDR_W=6 and BURST_BITS=2, which gives a 64-word array. A base near the top of the array therefore makes the burst offset wrap inside the last aligned group of four words, which shows that the upper bits stay fixed (R3) and the wrap returns to the base (R4). The small depth also lets the bench preload every word with a computed pattern. Every beat then has a distinct value that a reference model in the bench can predict.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_LOAD  = 2'd1,
    CYC_DESEL = 2'd2,
    CYC_STEP  = 2'd3
  } cyc_e;

endpackage

// File: rtl/bsr_burst_ctrl.sv
module bsr_burst_ctrl
  import bsr_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              en_a_n,
  input  logic              en_b_n,
  input  logic              en_c,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              active_o
);

  localparam int HI_W = ADDR_W - BURST_BITS;

  logic [ADDR_W-1:0]     base_q;
  logic [BURST_BITS-1:0] cnt_q;
  logic                  active_q;
  logic                  strobe;
  logic                  selected;
  cyc_e                  cyc;

  always_comb begin
    strobe   = !strobe_cpu_n || !strobe_ctl_n;
    selected = !en_a_n && !en_b_n && en_c;
    if (strobe)                   cyc = selected ? CYC_LOAD : CYC_DESEL;
    else if (active_q && !adv_n)  cyc = CYC_STEP;
    else                          cyc = CYC_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      unique case (cyc)
        CYC_LOAD: begin
          base_q   <= addr_i;
          cnt_q    <= '0;
          active_q <= 1'b1;
        end
        CYC_DESEL: active_q <= 1'b0;
        CYC_STEP:  cnt_q    <= cnt_q + 1'b1;
        default: ;
      endcase
    end
  end

  generate
    if (HI_W > 0) begin : g_hi
      assign cur_addr_o = {base_q[ADDR_W-1:BURST_BITS], base_q[BURST_BITS-1:0] + cnt_q};
    end else begin : g_lo
      assign cur_addr_o = base_q[BURST_BITS-1:0] + cnt_q;
    end
  endgenerate

  assign active_o = active_q;

  assert_load_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && selected) |=> (cnt_q == '0 && base_q == $past(addr_i) && active_q));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && active_q && !adv_n) |=> (cnt_q == $past(cnt_q) + 1'b1) && $stable(base_q));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && adv_n) |=> $stable(cnt_q) && $stable(base_q));

  assert_enables_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe) |=> $stable(active_q));

endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  task automatic load_word(input int idx, input logic [DATA_W-1:0] val);
    mem[idx] = val;
  endtask

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= mem[rd_addr_i];
  end

endmodule

// File: rtl/bsr_out_stage.sv
module bsr_out_stage #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              oe_n,
  output logic              drive_o,
  output logic [DATA_W-1:0] dq_o
);

  logic valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_i;
  end

  assign drive_o = valid_q && !oe_n;
  assign dq_o    = drive_o ? rdata_i : {DATA_W{1'bz}};

  assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i) |=> !drive_o);

endmodule

// File: rtl/burst_sram_rd.sv
module burst_sram_rd #(
  parameter int DATA_W     = 18,
  parameter int ADDR_W     = 10,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              en_a_n,
  input  logic              en_b_n,
  input  logic              en_c,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_o
);

  logic [ADDR_W-1:0] cur_addr;
  logic              active;
  logic [DATA_W-1:0] rdata;
  logic              drive;

  bsr_burst_ctrl #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
    .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c),
    .cur_addr_o(cur_addr), .active_o(active)
  );

  bsr_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr_i(cur_addr), .rdata_o(rdata)
  );

  bsr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .valid_i(active), .rdata_i(rdata),
    .oe_n(oe_n), .drive_o(drive), .dq_o(dq_o)
  );

  // R7: a deselect strobe floats the bus by the second edge
  assert_desel_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strobe_cpu_n || !strobe_ctl_n) && !(!en_a_n && !en_b_n && en_c)) |=> ##1 !drive);

  // R9: output enable high never drives the bus
  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drive);

endmodule

// File: tb/test_burst_sram_rd.sv
module test_burst_sram_rd;

  localparam int CLK_P  = 10;
  localparam int DW     = 18;
  localparam int AW     = 6;
  localparam int BB     = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1;
  logic          en_a_n = 1'b1, en_b_n = 1'b1, en_c = 1'b0, oe_n = 1'b1;
  wire  [DW-1:0] dq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  logic [AW-1:0] r_base = '0;
  logic [BB-1:0] r_cnt = '0;
  logic          r_act = 1'b0;
  logic          r_vld = 1'b0;
  logic [DW-1:0] r_dat = '0;

  burst_sram_rd #(.DATA_W(DW), .ADDR_W(AW), .BURST_BITS(BB)) i_burst_sram_rd (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
    .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c), .oe_n(oe_n), .dq_o(dq_o)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 32'h1F3) ^ 32'h2C35A);
  endfunction

  function automatic logic [AW-1:0] ref_addr();
    return {r_base[AW-1:BB], r_base[BB-1:0] + r_cnt};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: dq_o=%h expected=%h", tag, got, exp);
    end
  endtask

  // one cycle: drive at negedge, clock, update reference, check at next negedge
  task automatic step(input string tag, input logic sp, input logic sc, input logic adv,
                      input logic ea, input logic eb, input logic ec, input logic oe,
                      input logic [AW-1:0] a);
    logic strobe, sel;
    strobe_cpu_n = sp; strobe_ctl_n = sc; adv_n = adv;
    en_a_n = ea; en_b_n = eb; en_c = ec; oe_n = oe; addr_i = a;
    @(posedge clk);
    r_vld = r_act;
    r_dat = pat(int'(ref_addr()));
    strobe = !sp || !sc;
    sel = !ea && !eb && ec;
    if (strobe && sel) begin r_base = a; r_cnt = '0; r_act = 1'b1; end
    else if (strobe)   r_act = 1'b0;
    else if (r_act && !adv) r_cnt = r_cnt + 1'b1;
    @(negedge clk);
    check(tag, dq_o, (r_vld && !oe) ? r_dat : {DW{1'bz}});
  endtask

  task automatic go_idle(input int n);
    for (int i = 0; i < n; i++) step("R7", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    r_act = 0; r_vld = 0; r_cnt = '0; r_base = '0;
    check("R1 reset float", dq_o, {DW{1'bz}});
    step("R1", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
  endtask

  task automatic t_single_cpu();
    step("R2 load", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd9);
    step("R2 first", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
    check("R2 base word", dq_o, pat(9));
    go_idle(2);
  endtask

  task automatic t_burst_wrap();
    step("R2 ctl load", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd18);
    for (int k = 0; k < 5; k++) begin
      step("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
      check("R4 beat", dq_o, pat(16 + ((2 + k) % 4)));
    end
    go_idle(2);
  endtask

  task automatic t_top_wrap();
    step("R3 top load", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd63);
    step("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
    check("R3 top base", dq_o, pat(63));
    step("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
    check("R3 upper fixed", dq_o, pat(60));
    go_idle(2);
  endtask

  task automatic t_suspend();
    step("R5 load", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd33);
    step("R5", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
    step("R5", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
    check("R5 advanced", dq_o, pat(34));
    step("R5", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
    check("R5 held", dq_o, pat(34));
    go_idle(2);
  endtask

  task automatic t_restart();
    step("R6 load", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd40);
    step("R6", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
    step("R6 new", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd5);
    step("R6", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
    check("R6 new base", dq_o, pat(5));
    step("R6", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
    check("R6 next", dq_o, pat(6));
    go_idle(2);
  endtask

  task automatic t_deselect();
    step("R7 load", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd12);
    step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
    step("R7 desel", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 6'd0);
    step("R7", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
    check("R7 float", dq_o, {DW{1'bz}});
  endtask

  task automatic t_enables();
    for (int e = 0; e < 3; e++) begin
      step("R8 load", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd20);
      step("R8 desel", 1'b1, 1'b0, 1'b1, e == 0, e == 1, e != 2, 1'b0, 6'd0);
      step("R8", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0);
      check("R8 one enable off", dq_o, {DW{1'bz}});
    end
  endtask

  task automatic t_oe();
    go_idle(2);
    step("R9 load oe early", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd50);
    check("R9 early oe float", dq_o, {DW{1'bz}});
    step("R9 oe off", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd0);
    check("R9 oe high float", dq_o, {DW{1'bz}});
    oe_n = 1'b0;
    #1;
    check("R9 oe low drives", dq_o, pat(50));
    go_idle(2);
  endtask

  task automatic t_ignore_en();
    step("R10 load", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd44);
    step("R10", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0);
    step("R10", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0);
    check("R10 burst runs", dq_o, pat(45));
    go_idle(2);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) i_burst_sram_rd.u_array.load_word(i, pat(i));
    @(negedge clk);
    t_reset();
    t_single_cpu();
    t_burst_wrap();
    t_top_wrap();
    t_suspend();
    t_restart();
    t_deselect();
    t_enables();
    t_oe();
    t_ignore_en();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule